// File: doc/BRIEF.md
# Level-1 Capture Pipeline and Derandomizer

The block holds every bunch crossing's hit vector in a fixed-length delay line while the level-1 decision is being made. When a level-1 accept (L1A) arrives, three consecutive crossings are taken from a programmable tap: the crossing just before the triggered one, the triggered one, and the one after it. Each of the three becomes a tagged word that goes into a derandomizing FIFO. The FIFO is written on the crossing clock and drained on an independent readout clock, one word per readout cycle, toward a downstream collector.

A small capture state machine controls the write side. It has three states. In `CAP_IDLE` it waits for L1A. On an L1A that finds room in the FIFO, it writes the previous-crossing word and takes the transition *accept* to `CAP_CUR`. In `CAP_CUR` it writes the triggered-crossing word and takes the transition *advance* to `CAP_NEXT`. In `CAP_NEXT` it writes the next-crossing word and takes the transition *finish* back to `CAP_IDLE`. An L1A in `CAP_IDLE` that finds fewer than three free entries takes the transition *drop*: the machine stays in `CAP_IDLE` and raises a sticky overflow flag. The FIFO pointers cross the clock boundary as Gray codes through two-stage synchronizers.

Top module: `l1d_readout`

## Requirements
- R1: For an L1A sampled in crossing n with latency L (1 to PIPE_DEPTH-1), the block emits exactly three words, carrying the hit vectors of crossings n-L-1, n-L and n-L+1, in that order.
- R2: Word bits [HIT_W+1:HIT_W] hold the position within the window: 0 for the previous crossing, 1 for the triggered crossing and 2 for the next crossing.
- R3: Word bits [HIT_W+5:HIT_W+2] hold the 4-bit crossing counter value of that word's own crossing. The counter is 0 in the first crossing after reset and advances by one every write clock. A `bcr` pulse in crossing c makes crossing c+1 count 0.
- R4: An L1A that arrives in either of the two crossings after an accepted L1A is ignored and produces no words. An L1A three crossings after an accepted L1A is accepted.
- R5: An L1A in an idle crossing is accepted only if at least three FIFO entries are free. Otherwise none of its words are written, and `overflow` rises one cycle later and stays high.
- R6: An `ecr` pulse clears `overflow` at the next write-clock edge, and `ecr` takes priority over a simultaneous drop.
- R7: Words leave in write order with none lost or repeated, at most one per readout clock. `rd_valid` is high only in cycles that carry a word.
- R8: While reset is asserted, and immediately after it is released, `overflow` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Crossing (write) clock |
| wrst_n | input | 1 | Asynchronous active-low reset, write domain |
| hit_in | input | HIT_W | Hit vector of the current crossing |
| bcr | input | 1 | Crossing counter reset pulse |
| ecr | input | 1 | Event counter reset pulse; clears overflow |
| l1a | input | 1 | Level-1 accept |
| latency | input | $clog2(PIPE_DEPTH) | Trigger latency in crossings |
| overflow | output | 1 | Sticky flag: an event was dropped |
| rclk | input | 1 | Readout clock |
| rrst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_valid | output | 1 | A readout word is present |
| rd_data | output | HIT_W+6 | Readout word {tag, slot, hits} |

## Verification
The bench checks the window at the smallest latency of 1 and the largest of 31. An off-by-one in the tap would show up there as hits shifted by one crossing. It places a `bcr` pulse inside a window, so a tag taken from the L1A crossing instead of each word's own crossing shows up as a wrong or constant tag. It sends back-to-back L1As and one L1A exactly three crossings after an accepted one. A machine that retriggers would emit extra words, and one that stays busy too long would lose the second event. It also stops the read clock and fills the FIFO to one free entry. A design without the three-entry reserve would write a partial event, and one without a sticky flag would clear `overflow` after draining.

// File: rtl/l1d_pkg.sv
`timescale 1ns/1ps
package l1d_pkg;
    typedef enum logic [1:0] {
        SLOT_PREV = 2'd0,
        SLOT_CUR  = 2'd1,
        SLOT_NEXT = 2'd2
    } slot_e;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_CUR,
        CAP_NEXT
    } cap_state_e;
endpackage

// File: rtl/l1d_pipe.sv
`timescale 1ns/1ps
module l1d_pipe #(
    parameter int ENT_W = 20,
    parameter int DEPTH = 32,
    localparam int LAT_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ENT_W-1:0] din,
    input  logic [LAT_W-1:0] lat,
    output logic [ENT_W-1:0] tap
);
    logic [ENT_W-1:0] stage [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    // stage[k] holds the crossing sampled k+1 edges back
    assign tap = stage[lat];
endmodule

// File: rtl/l1d_capture.sv
`timescale 1ns/1ps
module l1d_capture
    import l1d_pkg::*;
#(
    parameter int HIT_W = 16,
    parameter int TAG_W = 4,
    localparam int WORD_W = HIT_W + TAG_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIT_W-1:0]  hit_in,
    input  logic              bcr,
    input  logic              ecr,
    input  logic              l1a,
    input  logic              room3,
    input  logic [HIT_W-1:0]  tap_hit,
    input  logic [TAG_W-1:0]  tap_tag,
    output logic [HIT_W+TAG_W-1:0] pipe_din,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word,
    output logic              overflow
);
    cap_state_e state, state_nx;
    slot_e      slot;
    logic       drop;
    logic [TAG_W-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        wr_en    = 1'b0;
        slot     = SLOT_PREV;
        drop     = 1'b0;
        unique case (state)
            CAP_IDLE: begin
                if (l1a) begin
                    if (room3) begin
                        wr_en    = 1'b1;
                        slot     = SLOT_PREV;
                        state_nx = CAP_CUR;
                    end else begin
                        drop = 1'b1;
                    end
                end
            end
            CAP_CUR: begin
                wr_en    = 1'b1;
                slot     = SLOT_CUR;
                state_nx = CAP_NEXT;
            end
            CAP_NEXT: begin
                wr_en    = 1'b1;
                slot     = SLOT_NEXT;
                state_nx = CAP_IDLE;
            end
            default: state_nx = CAP_IDLE;
        endcase
    end

    assign wr_word  = {tap_tag, slot, tap_hit};
    assign pipe_din = {bcnt, hit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   bcnt <= '0;
        else if (bcr) bcnt <= '0;
        else          bcnt <= bcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    overflow <= 1'b0;
        else if (ecr)  overflow <= 1'b0;
        else if (drop) overflow <= 1'b1;
    end

    // R2: the next-crossing word directly follows the triggered-crossing word
    p_slot_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot == SLOT_NEXT) |-> $past(wr_en && slot == SLOT_CUR));

    // R4: a window always closes; L1A during it cannot restart capture
    p_no_retrigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_NEXT) |=> (state == CAP_IDLE));

    // R5: an L1A refused for lack of room sets the flag
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_IDLE && l1a && !room3 && !ecr) |=> overflow);

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ecr) |=> overflow);

    // R6: ecr clears the flag
    p_ecr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ecr |=> !overflow);
endmodule

// File: rtl/l1d_fifo.sv
`timescale 1ns/1ps
module l1d_fifo #(
    parameter int W       = 22,
    parameter int DEPTH   = 16,
    parameter int RESERVE = 3,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         room3,
    input  logic         rclk,
    input  logic         rrst_n,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] wg_s1, wg_s2, rg_s1, rg_s2;
    logic [PW-1:0] wbin_nx, rbin_nx, used_w;
    logic          empty;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // write domain
    assign wbin_nx = wbin + 1'b1;
    assign used_w  = wbin - g2b(rg_s2);
    assign room3   = (PW'(DEPTH) - used_w) >= PW'(RESERVE);

    always_ff @(posedge wclk) begin
        if (wr_en) mem[wbin[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
            rg_s1 <= '0;
            rg_s2 <= '0;
        end else begin
            rg_s1 <= rgray;
            rg_s2 <= rg_s1;
            if (wr_en) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
        end
    end

    // read domain
    assign rbin_nx = rbin + 1'b1;
    assign empty   = (rgray == wg_s2);

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            wg_s1    <= '0;
            wg_s2    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            wg_s1 <= wgray;
            wg_s2 <= wg_s1;
            if (!empty) begin
                rd_data  <= mem[rbin[AW-1:0]];
                rd_valid <= 1'b1;
                rbin     <= rbin_nx;
                rgray    <= rbin_nx ^ (rbin_nx >> 1);
            end else begin
                rd_valid <= 1'b0;
            end
        end
    end

    // R5: no write is ever issued into a full FIFO
    p_no_overflow_r5: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_en |-> (used_w < PW'(DEPTH)));

    // R7: pointers crossing the boundary change one bit at a time
    p_wgray_step_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    p_rgray_step_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/l1d_readout.sv
`timescale 1ns/1ps
module l1d_readout #(
    parameter int HIT_W      = 16,
    parameter int PIPE_DEPTH = 32,
    parameter int FIFO_DEPTH = 16,
    localparam int TAG_W  = 4,
    localparam int ENT_W  = HIT_W + TAG_W,
    localparam int WORD_W = HIT_W + TAG_W + 2,
    localparam int LAT_W  = $clog2(PIPE_DEPTH)
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic [HIT_W-1:0]  hit_in,
    input  logic              bcr,
    input  logic              ecr,
    input  logic              l1a,
    input  logic [LAT_W-1:0]  latency,
    output logic              overflow,
    input  logic              rclk,
    input  logic              rrst_n,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    logic [ENT_W-1:0]  pipe_din, tap;
    logic              wr_en, room3;
    logic [WORD_W-1:0] wr_word;

    l1d_capture #(.HIT_W(HIT_W), .TAG_W(TAG_W)) u_capture (
        .clk      (wclk),
        .rst_n    (wrst_n),
        .hit_in   (hit_in),
        .bcr      (bcr),
        .ecr      (ecr),
        .l1a      (l1a),
        .room3    (room3),
        .tap_hit  (tap[HIT_W-1:0]),
        .tap_tag  (tap[ENT_W-1:HIT_W]),
        .pipe_din (pipe_din),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .overflow (overflow)
    );

    l1d_pipe #(.ENT_W(ENT_W), .DEPTH(PIPE_DEPTH)) u_pipe (
        .clk   (wclk),
        .rst_n (wrst_n),
        .din   (pipe_din),
        .lat   (latency),
        .tap   (tap)
    );

    l1d_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH), .RESERVE(3)) u_fifo (
        .wclk     (wclk),
        .wrst_n   (wrst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_word),
        .room3    (room3),
        .rclk     (rclk),
        .rrst_n   (rrst_n),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/test_l1d_readout.sv
`timescale 1ns/1ps
module test_l1d_readout;
    localparam int HW = 16;
    localparam int WW = HW + 6;

    logic          wclk = 1'b0, rclk = 1'b0, rclk_run = 1'b1;
    logic          wrst_n, rrst_n, bcr, ecr, l1a;
    logic [HW-1:0] hit_in;
    logic [4:0]    latency;
    logic          overflow, rd_valid;
    logic [WW-1:0] rd_data;

    int total = 0, fails = 0;
    int cyc = 0, lat_m = 5, busy_m = 0;
    bit expect_room = 1'b1;
    logic [3:0]    bcnt_m = '0;
    logic [HW-1:0] h_hist [8192];
    logic [3:0]    b_hist [8192];
    logic [WW-1:0] exp_q [$];

    always #2.5 wclk = ~wclk;
    always #3.5 if (rclk_run) rclk = ~rclk;

    l1d_readout i_l1d_readout (
        .wclk(wclk), .wrst_n(wrst_n), .hit_in(hit_in), .bcr(bcr), .ecr(ecr),
        .l1a(l1a), .latency(latency), .overflow(overflow), .rclk(rclk),
        .rrst_n(rrst_n), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // driver: one crossing, pushes the expected window on an accepted L1A
    task automatic step(input logic b, input logic e, input logic a);
        logic [HW-1:0] h;
        h = HW'($urandom);
        hit_in = h; bcr = b; ecr = e; l1a = a;
        h_hist[cyc] = h;
        b_hist[cyc] = bcnt_m;
        if (busy_m > 0) busy_m--;
        else if (a && expect_room) begin
            for (int j = 0; j < 3; j++) begin
                int c;
                c = cyc - lat_m - 1 + j;
                exp_q.push_back({b_hist[c], 2'(j), h_hist[c]});
            end
            busy_m = 2;
        end
        bcnt_m = b ? 4'd0 : bcnt_m + 4'd1;
        cyc++;
        @(negedge wclk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic drain();
        for (int g = 0; g < 3000 && exp_q.size() != 0; g++) step(1'b0, 1'b0, 1'b0);
        idle(10);
    endtask

    // monitor: scoreboard compare, field by field
    always @(negedge rclk) begin
        if (rrst_n && rd_valid) begin
            logic [WW-1:0] e;
            if (exp_q.size() == 0) begin
                total++; fails++;
                $display("FAIL R4: actual extra word %0h expected none", rd_data);
            end else begin
                e = exp_q.pop_front();
                chk("R1 hits", 32'(rd_data[HW-1:0]), 32'(e[HW-1:0]));
                chk("R2 slot", 32'(rd_data[HW+1:HW]), 32'(e[HW+1:HW]));
                chk("R3 tag", 32'(rd_data[HW+5:HW+2]), 32'(e[HW+5:HW+2]));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge wclk);
        total++; fails++;
        $display("FAIL R7: actual hung run expected completion");
        summary();
        $finish;
    end

    initial begin
        wrst_n = 1'b0; rrst_n = 1'b0;
        hit_in = '0; bcr = 1'b0; ecr = 1'b0; l1a = 1'b0; latency = 5'd5;
        repeat (4) @(negedge wclk);
        chk("R8 overflow in reset", 32'(overflow), 0);
        chk("R8 rd_valid in reset", 32'(rd_valid), 0);
        wrst_n = 1'b1; rrst_n = 1'b1;
        idle(40);
        chk("R8 overflow after reset", 32'(overflow), 0);
        chk("R8 rd_valid after reset", 32'(rd_valid), 0);

        // R1: nominal latency, several events
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b0, 1'b1);
            idle(15);
        end

        // R3: bcr inside the window
        idle(10);
        step(1'b1, 1'b0, 1'b0);
        idle(3);
        step(1'b0, 1'b0, 1'b1);
        idle(15);

        // R1 boundaries: latency 1 and 31
        drain();
        lat_m = 1; latency = 5'd1;
        step(1'b0, 1'b0, 1'b1);
        idle(15);
        drain();
        lat_m = 31; latency = 5'd31;
        step(1'b0, 1'b0, 1'b1);
        idle(15);
        drain();
        lat_m = 5; latency = 5'd5;

        // R4: back-to-back L1A ignored, third crossing after accepted
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        idle(20);
        drain();

        // R5: stop readout, fill to one free entry
        rclk_run = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 1'b0, 1'b1);
            idle(3);
        end
        chk("R5 no overflow with room", 32'(overflow), 0);
        expect_room = 1'b0;
        step(1'b0, 1'b0, 1'b1);
        chk("R5 overflow on drop", 32'(overflow), 1);
        idle(3);
        step(1'b0, 1'b0, 1'b1);
        expect_room = 1'b1;
        idle(2);
        rclk_run = 1'b1;
        drain();
        chk("R5 overflow sticky", 32'(overflow), 1);

        // R6: ecr clears, then normal operation resumes
        step(1'b0, 1'b1, 1'b0);
        chk("R6 overflow cleared", 32'(overflow), 0);
        step(1'b0, 1'b0, 1'b1);
        idle(20);
        drain();
        idle(20);
        chk("R7 all words delivered", 32'(exp_q.size()), 0);
        summary();
        $finish;
    end
endmodule